// File: doc/BRIEF.md
# Halfword Host Port to Word Register Bridge

This block lets a 16-bit asynchronous host bus, with separate address and data lines, reach internal storage that is 32 bits wide. Every host access becomes one word-wide request on an internal port that uses a request/ready handshake, together with a per-byte write enable. One address bit picks the half of the word that is touched. Within that half, two active-low lane enables pick the high byte, the low byte or both. Byte order is big-endian: the byte at the lowest byte address is word bits 31:24.

A mode pin chooses between two host bus styles. In the strobe-plus-direction style, the host gives a data strobe, a read/write direction line and lane enables, and gets back an active-low acknowledge. In the separate read/write strobe style, the block holds an active-low wait from the strobe until the internal data is ready.

The address space has four regions: connection memory (read/write), data memory (read-only), control registers (read/write) and an undefined region. An access that is not allowed returns an active-low bus error instead of a request. The bus-facing outputs have output enables that a pad ring uses to release the lines. When chip select is released in the middle of a cycle, the handshake lines are first driven inactive-high for one cycle and only then released.

Top module: `hbb_bridge`

## Requirements
- R1: While the asynchronous active-low reset is low, and after it, with no access running: `hs_oe`=0, `hdata_oe`=0, `mem_req`=0, and `ack_n`, `berr_n`, `wait_n` are all 1.
- R2: A halfword write puts host data bit k on word bits k+16 and k. Address bit 1 = 0 enables bytes 3:2 (`mem_be`=1100). Address bit 1 = 1 enables bytes 1:0 (`mem_be`=0011).
- R3: Byte writes are big-endian. `lane_n[1]`=0 enables host byte 15:8 and `lane_n[0]`=0 enables host byte 7:0. With address bit 1 = 0, the high lane alone gives `mem_be`=1000 (word bits 31:24). With address bit 1 = 1, the low lane alone gives `mem_be`=0001 (word bits 7:0). Other bytes of the word are unchanged.
- R4: A read returns word bits 31:16 when address bit 1 = 0 and bits 15:0 when it is 1, with `hdata_oe`=1 during the completed cycle.
- R5: A write to the data memory region (address bits 11:10 = 01) gives `berr_n`=0, issues no internal request and leaves that word unchanged. A read of that region completes normally.
- R6: Any access to the undefined region (address bits 11:10 = 11) gives `berr_n`=0 and issues no internal request.
- R7: While `init_busy`=1, accesses to connection memory (00) or data memory (01) give `berr_n`=0 with no request. Control register accesses (10) still complete.
- R8: In the strobe-plus-direction style (`bus_mode`=0), `ack_n` goes low only after the internal ready and stays low while the data strobe is held. After the strobe is released, with chip select still low, `ack_n` returns high and stays driven (`hs_oe`=1).
- R9: In the separate-strobe style (`bus_mode`=1), `wait_n` goes low after the strobe and returns high only once the internal request has been accepted. Read data is then valid.
- R10: Once chip select is released at the end of a cycle, `hdata_oe` and `hs_oe` go to 0.
- R11: If chip select is released while the strobe is still active, the handshake lines are driven high with `hs_oe`=1 for at least one cycle before `hs_oe` drops to 0.
- R12: Asserting the reset in the middle of an access forces `mem_req`=0 and `hs_oe`=0 at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_mode | input | 1 | 0 = strobe-plus-direction style, 1 = separate read/write strobes |
| cs_n | input | 1 | Chip select, active low |
| ds_n | input | 1 | Data strobe (mode 0), active low |
| rw | input | 1 | Direction (mode 0): 1 read, 0 write |
| rd_n | input | 1 | Read strobe (mode 1), active low |
| wr_n | input | 1 | Write strobe (mode 1), active low |
| lane_n | input | 2 | Byte lane enables, active low; bit 1 = host bits 15:8 |
| haddr | input | AW-1 | Halfword address, byte address bits AW-1:1 |
| hwdata | input | 16 | Host write data |
| hrdata | output | 16 | Host read data |
| hdata_oe | output | 1 | Enable for the host data drivers |
| ack_n | output | 1 | Data acknowledge, active low |
| berr_n | output | 1 | Bus error, active low |
| wait_n | output | 1 | Wait, active low |
| hs_oe | output | 1 | Enable for the acknowledge, bus error and wait drivers |
| init_busy | input | 1 | Memory initialization in progress |
| mem_req | output | 1 | Internal request |
| mem_we | output | 1 | Internal write |
| mem_addr | output | AW-2 | Internal word address |
| mem_be | output | 4 | Internal byte enables, bit 3 = bits 31:24 |
| mem_wdata | output | 32 | Internal write data |
| mem_rdata | input | 32 | Internal read data |
| mem_rdy | input | 1 | Internal ready |

## Verification
The hardest situation to reach from the ports is a chip select that is released while the data strobe is still held. Here the handshake lines must be parked high before their enable drops. The stimulus first completes a read until the acknowledge appears. It then raises only chip select and samples every cycle afterwards, so that the one-cycle inactive-high window can be seen on its own. The blocked-write cases need a second look: the bench counts accepted internal requests and reads the word back, which shows that no data reached storage.

// File: rtl/hbb_pkg.sv
package hbb_pkg;
   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_ACC  = 3'd1,
      ST_DONE = 3'd2,
      ST_ERR  = 3'd3,
      ST_PARK = 3'd4
   } hbb_state_e;

   typedef enum logic [1:0] {
      RGN_CONN = 2'd0,
      RGN_DATA = 2'd1,
      RGN_CTRL = 2'd2,
      RGN_VOID = 2'd3
   } hbb_rgn_e;
endpackage

// File: rtl/hbb_sync.sv
module hbb_sync #(
   parameter int            W       = 1,
   parameter int            STAGES  = 2,
   parameter logic [W-1:0]  RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 0 || STAGES > 4) begin : g_bad
      $error("hbb_sync: STAGES out of range");
   end

   if (STAGES == 0) begin : g_pass
      assign q = d;
   end else begin : g_chain
      logic [W-1:0] chain [STAGES];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) chain[i] <= RST_VAL;
         end else begin
            chain[0] <= d;
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
         end
      end
      assign q = chain[STAGES-1];
   end
endmodule

// File: rtl/hbb_decode.sv
module hbb_decode import hbb_pkg::*; (
   input  logic [1:0] rgn_bits,
   input  logic       is_write,
   input  logic       init_busy,
   output logic       err
);
   hbb_rgn_e rgn;
   logic     mem_space;

   always_comb begin
      rgn       = hbb_rgn_e'(rgn_bits);
      mem_space = (rgn == RGN_CONN) || (rgn == RGN_DATA);
      err       = (rgn == RGN_VOID)
               || ((rgn == RGN_DATA) && is_write)
               || (mem_space && init_busy);
   end
endmodule

// File: rtl/hbb_lanes.sv
module hbb_lanes #(
   parameter int HW = 16,
   localparam int IW = 2 * HW,
   localparam int HB = HW / 8,
   localparam int BW = IW / 8
) (
   input  logic          a1,
   input  logic [HB-1:0] lane_n,
   input  logic [HW-1:0] hw_in,
   input  logic [IW-1:0] word_in,
   output logic [BW-1:0] be,
   output logic [IW-1:0] word_out,
   output logic [HW-1:0] hw_out
);
   // half 1 holds the upper word bits and is chosen by a1 = 0 (big-endian)
   for (genvar h = 0; h < 2; h++) begin : g_half
      assign be[h*HB +: HB]       = (a1 == (h == 0)) ? ~lane_n : '0;
      assign word_out[h*HW +: HW] = hw_in;
   end

   assign hw_out = a1 ? word_in[HW-1:0] : word_in[IW-1:HW];
endmodule

// File: rtl/hbb_bridge.sv
module hbb_bridge import hbb_pkg::*; #(
   parameter int AW          = 12,
   parameter int HW          = 16,
   parameter int SYNC_STAGES = 2,
   localparam int IW  = 2 * HW,
   localparam int HB  = HW / 8,
   localparam int BW  = IW / 8,
   localparam int WAW = AW - 2
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           bus_mode,
   input  logic           cs_n,
   input  logic           ds_n,
   input  logic           rw,
   input  logic           rd_n,
   input  logic           wr_n,
   input  logic [HB-1:0]  lane_n,
   input  logic [AW-1:1]  haddr,
   input  logic [HW-1:0]  hwdata,
   output logic [HW-1:0]  hrdata,
   output logic           hdata_oe,
   output logic           ack_n,
   output logic           berr_n,
   output logic           wait_n,
   output logic           hs_oe,
   input  logic           init_busy,
   output logic           mem_req,
   output logic           mem_we,
   output logic [WAW-1:0] mem_addr,
   output logic [BW-1:0]  mem_be,
   output logic [IW-1:0]  mem_wdata,
   input  logic [IW-1:0]  mem_rdata,
   input  logic           mem_rdy
);
   if (HW % 8 != 0 || HW < 8) begin : g_bad_hw
      $error("hbb_bridge: HW must be a multiple of 8");
   end
   if (AW < 5) begin : g_bad_aw
      $error("hbb_bridge: AW too small for region decode");
   end

   // control pins: {cs_n, ds_n, rd_n, wr_n, bus_mode}
   logic [4:0] ctl_raw, ctl_s;
   assign ctl_raw = {cs_n, ds_n, rd_n, wr_n, bus_mode};

   hbb_sync #(.W(5), .STAGES(SYNC_STAGES), .RST_VAL(5'b11110)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (ctl_raw),
      .q     (ctl_s)
   );

   logic cs_act, strobe_act, wr_c, mode_s;
   always_comb begin
      mode_s     = ctl_s[0];
      cs_act     = !ctl_s[4];
      strobe_act = mode_s ? (!ctl_s[2] || !ctl_s[1]) : !ctl_s[3];
      wr_c       = mode_s ? !ctl_s[1] : !rw;
   end

   logic err_c;
   hbb_decode u_dec (
      .rgn_bits  (haddr[AW-1:AW-2]),
      .is_write  (wr_c),
      .init_busy (init_busy),
      .err       (err_c)
   );

   hbb_state_e      state;
   logic            mode_q, we_q, a1_q, err_q;
   logic [HB-1:0]   lane_q;
   logic [WAW-1:0]  addr_q;
   logic [HW-1:0]   hw_q, rd_q, rd_half;

   hbb_lanes #(.HW(HW)) u_lanes (
      .a1       (a1_q),
      .lane_n   (lane_q),
      .hw_in    (hw_q),
      .word_in  (mem_rdata),
      .be       (mem_be),
      .word_out (mem_wdata),
      .hw_out   (rd_half)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         mode_q <= 1'b0;
         we_q   <= 1'b0;
         a1_q   <= 1'b0;
         err_q  <= 1'b0;
         lane_q <= '1;
         addr_q <= '0;
         hw_q   <= '0;
         rd_q   <= '0;
      end else begin
         unique case (state)
            ST_IDLE: if (cs_act && strobe_act) begin
               mode_q <= mode_s;
               we_q   <= wr_c;
               a1_q   <= haddr[1];
               lane_q <= lane_n;
               addr_q <= haddr[AW-1:2];
               hw_q   <= hwdata;
               err_q  <= err_c;
               state  <= ST_ACC;
            end
            ST_ACC: begin
               if (err_q) begin
                  state <= ST_ERR;
               end else if (mem_rdy) begin
                  rd_q  <= rd_half;
                  state <= ST_DONE;
               end
            end
            ST_DONE, ST_ERR: begin
               if (!cs_act)          state <= ST_PARK;
               else if (!strobe_act) state <= ST_IDLE;
            end
            ST_PARK: state <= ST_IDLE;
            default: state <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      mem_req  = (state == ST_ACC) && !err_q;
      mem_we   = we_q;
      mem_addr = addr_q;
      hrdata   = rd_q;
      hdata_oe = cs_act && (state == ST_DONE) && !we_q;
      hs_oe    = cs_act || (state != ST_IDLE);
      ack_n    = !((state == ST_DONE) && !mode_q);
      berr_n   = !(state == ST_ERR);
      wait_n   = !((state == ST_ACC) && mode_q);
   end
endmodule

// File: rtl/hbb_bridge_chk.sv
module hbb_bridge_chk #(
   parameter int AW = 12,
   parameter int BW = 4
) (
   input logic          clk,
   input logic          rst_n,
   input logic          hs_oe,
   input logic          hdata_oe,
   input logic          ack_n,
   input logic          berr_n,
   input logic          wait_n,
   input logic          mem_req,
   input logic          mem_we,
   input logic [AW-3:0] mem_addr,
   input logic [BW-1:0] mem_be,
   input logic          mem_rdy
);
   assert_be_one_half_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we) |-> ((mem_be[BW-1:BW/2] == '0) != (mem_be[BW/2-1:0] == '0)));

   assert_no_ro_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we) |-> (mem_addr[AW-3 -: 2] != 2'b01));

   assert_no_void_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> (mem_addr[AW-3 -: 2] != 2'b11));

   assert_ack_berr_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !(!ack_n && !berr_n));

   assert_req_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_rdy) |=> (mem_req && $stable(mem_addr)));

   assert_wait_ends_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!wait_n && mem_req && mem_rdy) |=> wait_n);

   assert_data_needs_hs_R10: assert property (@(posedge clk) disable iff (!rst_n)
      hdata_oe |-> hs_oe);

   assert_park_before_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(hs_oe) |-> ($past(ack_n) && $past(berr_n) && $past(wait_n)));
endmodule

bind hbb_bridge hbb_bridge_chk #(.AW(AW), .BW(BW)) u_chk (.*);

// File: tb/hbb_bridge_test.sv
module hbb_bridge_test;
   localparam int AW  = 12;
   localparam int LAT = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_mode = 1'b0;
   logic        cs_n = 1'b1, ds_n = 1'b1, rw = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
   logic [1:0]  lane_n = 2'b00;
   logic [AW-1:1] haddr = '0;
   logic [15:0] hwdata = '0;
   logic [15:0] hrdata;
   logic        hdata_oe, ack_n, berr_n, wait_n, hs_oe;
   logic        init_busy = 1'b0;
   logic        mem_req, mem_we, mem_rdy;
   logic [AW-3:0] mem_addr;
   logic [3:0]  mem_be;
   logic [31:0] mem_wdata, mem_rdata;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   always #4 clk = ~clk;

   hbb_bridge #(.AW(AW)) uut (
      .clk(clk), .rst_n(rst_n), .bus_mode(bus_mode), .cs_n(cs_n), .ds_n(ds_n),
      .rw(rw), .rd_n(rd_n), .wr_n(wr_n), .lane_n(lane_n), .haddr(haddr),
      .hwdata(hwdata), .hrdata(hrdata), .hdata_oe(hdata_oe), .ack_n(ack_n),
      .berr_n(berr_n), .wait_n(wait_n), .hs_oe(hs_oe), .init_busy(init_busy),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_rdy(mem_rdy)
   );

   // storage model with fixed ready latency
   logic [31:0] store [1024];
   int          lat_cnt;
   int          req_cnt;
   logic [3:0]  last_be;
   logic [31:0] last_wd;

   function automatic logic [31:0] pat(input int i);
      return {16'hA000 | 16'(i), 16'h5000 | 16'(i)};
   endfunction

   assign mem_rdy   = mem_req && (lat_cnt == LAT);
   assign mem_rdata = store[mem_addr];

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lat_cnt <= 0;
         req_cnt <= 0;
         last_be <= '0;
         last_wd <= '0;
         for (int i = 0; i < 1024; i++) store[i] <= pat(i);
      end else begin
         lat_cnt <= (mem_req && !mem_rdy) ? lat_cnt + 1 : 0;
         if (mem_req && mem_rdy) begin
            req_cnt <= req_cnt + 1;
            last_be <= mem_be;
            last_wd <= mem_wdata;
            if (mem_we)
               for (int b = 0; b < 4; b++)
                  if (mem_be[b]) store[mem_addr][b*8 +: 8] <= mem_wdata[b*8 +: 8];
         end
      end
   end

   function automatic logic [10:0] mk(input logic [1:0] rgn, input logic [7:0] w, input logic a1);
      return {rgn, w, a1};
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic do_cycle(input logic md, input logic wr, input logic [10:0] a,
                           input logic [1:0] ln, input logic [15:0] wd,
                           output logic got_ack, output logic got_berr,
                           output logic [15:0] rdv, output logic dat_oe,
                           output logic saw_wait);
      if (bus_mode !== md) begin
         @(negedge clk) bus_mode = md;
         repeat (4) @(negedge clk);
      end
      @(negedge clk);
      haddr = a; lane_n = ln; hwdata = wd; rw = !wr; cs_n = 1'b0;
      if (!md) ds_n = 1'b0;
      else if (wr) wr_n = 1'b0;
      else rd_n = 1'b0;
      got_ack = 0; got_berr = 0; saw_wait = 0;
      for (int k = 0; k < 40; k++) begin
         @(negedge clk);
         if (!wait_n) saw_wait = 1;
         if (!berr_n) begin got_berr = 1; break; end
         if (!md && !ack_n) begin got_ack = 1; break; end
         if (md && saw_wait && wait_n) begin got_ack = 1; break; end
      end
      rdv = hrdata;
      dat_oe = hdata_oe;
   endtask

   task automatic rel_strobe();
      ds_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
      repeat (4) @(negedge clk);
   endtask

   task automatic rel_cs();
      cs_n = 1'b1;
      repeat (4) @(negedge clk);
   endtask

   task automatic access(input logic md, input logic wr, input logic [10:0] a,
                         input logic [1:0] ln, input logic [15:0] wd,
                         output logic got_ack, output logic got_berr,
                         output logic [15:0] rdv);
      logic oe, sw;
      do_cycle(md, wr, a, ln, wd, got_ack, got_berr, rdv, oe, sw);
      rel_strobe();
      rel_cs();
   endtask

   task automatic t_reset();
      chk("R1 hs_oe", hs_oe, 0);
      chk("R1 hdata_oe", hdata_oe, 0);
      chk("R1 mem_req", mem_req, 0);
      chk("R1 handshake", {ack_n, berr_n, wait_n}, 3'b111);
   endtask

   task automatic t_halfword();
      logic ak, be; logic [15:0] rv;
      access(0, 1, mk(2'b00, 8'd5, 0), 2'b00, 16'h1234, ak, be, rv);
      chk("R2 upper ack", ak, 1);
      chk("R2 upper be", last_be, 4'b1100);
      chk("R2 upper wdata", last_wd[31:16], 16'h1234);
      access(0, 1, mk(2'b00, 8'd6, 1), 2'b00, 16'hBEEF, ak, be, rv);
      chk("R2 lower be", last_be, 4'b0011);
      chk("R2 lower wdata", last_wd[15:0], 16'hBEEF);
      access(0, 0, mk(2'b00, 8'd5, 0), 2'b00, 16'h0, ak, be, rv);
      chk("R4 read upper", rv, 16'h1234);
      access(0, 0, mk(2'b00, 8'd5, 1), 2'b00, 16'h0, ak, be, rv);
      chk("R4 read lower", rv, pat(5)[15:0]);
      access(0, 0, mk(2'b00, 8'd6, 1), 2'b00, 16'h0, ak, be, rv);
      chk("R4 read lower written", rv, 16'hBEEF);
   endtask

   task automatic t_bytes();
      logic ak, be; logic [15:0] rv;
      access(0, 1, mk(2'b00, 8'd9, 0), 2'b01, 16'h77AA, ak, be, rv);
      chk("R3 byte0 be", last_be, 4'b1000);
      access(0, 1, mk(2'b00, 8'd9, 1), 2'b10, 16'hAA33, ak, be, rv);
      chk("R3 byte3 be", last_be, 4'b0001);
      access(0, 0, mk(2'b00, 8'd9, 0), 2'b00, 16'h0, ak, be, rv);
      chk("R3 upper half", rv, {8'h77, pat(9)[23:16]});
      access(0, 0, mk(2'b00, 8'd9, 1), 2'b00, 16'h0, ak, be, rv);
      chk("R3 lower half", rv, {pat(9)[15:8], 8'h33});
   endtask

   task automatic t_ro_write();
      logic ak, be; logic [15:0] rv; int n0;
      n0 = req_cnt;
      access(0, 1, mk(2'b01, 8'd3, 0), 2'b00, 16'hDEAD, ak, be, rv);
      chk("R5 berr", {ak, be}, 2'b01);
      chk("R5 no request", req_cnt, n0);
      access(0, 0, mk(2'b01, 8'd3, 0), 2'b00, 16'h0, ak, be, rv);
      chk("R5 read allowed", {ak, be}, 2'b10);
      chk("R5 word unchanged", rv, pat(256 + 3)[31:16]);
   endtask

   task automatic t_void();
      logic ak, be; logic [15:0] rv; int n0;
      n0 = req_cnt;
      access(0, 0, mk(2'b11, 8'd1, 0), 2'b00, 16'h0, ak, be, rv);
      chk("R6 read berr", {ak, be}, 2'b01);
      access(1, 1, mk(2'b11, 8'd2, 1), 2'b00, 16'h5555, ak, be, rv);
      chk("R6 write berr", {ak, be}, 2'b01);
      chk("R6 no request", req_cnt, n0);
   endtask

   task automatic t_busy();
      logic ak, be; logic [15:0] rv; int n0;
      init_busy = 1'b1;
      n0 = req_cnt;
      access(0, 0, mk(2'b00, 8'd5, 0), 2'b00, 16'h0, ak, be, rv);
      chk("R7 conn busy berr", {ak, be}, 2'b01);
      access(0, 0, mk(2'b01, 8'd4, 1), 2'b00, 16'h0, ak, be, rv);
      chk("R7 data busy berr", {ak, be}, 2'b01);
      chk("R7 no request", req_cnt, n0);
      access(0, 1, mk(2'b10, 8'd7, 0), 2'b00, 16'hC0C0, ak, be, rv);
      chk("R7 ctrl ack", {ak, be}, 2'b10);
      init_busy = 1'b0;
   endtask

   task automatic t_ack_hold();
      logic ak, be, oe, sw; logic [15:0] rv;
      do_cycle(0, 0, mk(2'b10, 8'd7, 0), 2'b00, 16'h0, ak, be, rv, oe, sw);
      chk("R8 ack", ak, 1);
      chk("R4 data oe", oe, 1);
      chk("R8 ctrl data", rv, 16'hC0C0);
      repeat (3) @(negedge clk);
      chk("R8 ack held", ack_n, 0);
      rel_strobe();
      chk("R8 ack high after strobe", {hs_oe, ack_n}, 2'b11);
      rel_cs();
      chk("R10 released", {hs_oe, hdata_oe}, 2'b00);
   endtask

   task automatic t_mode1();
      logic ak, be, oe, sw; logic [15:0] rv; int n0;
      n0 = req_cnt;
      do_cycle(1, 1, mk(2'b00, 8'd20, 1), 2'b00, 16'h4242, ak, be, rv, oe, sw);
      chk("R9 write wait seen", sw, 1);
      chk("R9 write done", ak, 1);
      chk("R9 wait ends after ready", req_cnt, n0 + 1);
      rel_strobe(); rel_cs();
      do_cycle(1, 0, mk(2'b00, 8'd20, 1), 2'b00, 16'h0, ak, be, rv, oe, sw);
      chk("R9 read wait seen", sw, 1);
      chk("R9 read data", rv, 16'h4242);
      chk("R9 read oe", oe, 1);
      chk("R9 no ack in mode1", ack_n, 1);
      rel_strobe(); rel_cs();
   endtask

   task automatic t_early_cs();
      logic ak, be, oe, sw, prev_ack, park_ok, saw_park; logic [15:0] rv;
      do_cycle(0, 0, mk(2'b00, 8'd5, 0), 2'b00, 16'h0, ak, be, rv, oe, sw);
      chk("R11 ack before release", ak, 1);
      cs_n = 1'b1;
      prev_ack = ack_n; park_ok = 1; saw_park = 0;
      for (int k = 0; k < 8; k++) begin
         @(negedge clk);
         if (hs_oe && ack_n && berr_n && wait_n) saw_park = 1;
         if (!hs_oe && !prev_ack) park_ok = 0;
         prev_ack = hs_oe ? ack_n : 1'b1;
      end
      chk("R11 parked high", saw_park, 1);
      chk("R11 no release while low", park_ok, 1);
      chk("R11 finally released", {hs_oe, hdata_oe}, 2'b00);
      rel_strobe();
   endtask

   task automatic t_async_reset();
      @(negedge clk);
      haddr = mk(2'b00, 8'd1, 0); rw = 1'b1; cs_n = 1'b0; ds_n = 1'b0;
      for (int k = 0; k < 20; k++) begin
         @(negedge clk);
         if (mem_req) break;
      end
      chk("R12 request running", mem_req, 1);
      #1 rst_n = 1'b0;
      #1;
      chk("R12 req dropped", mem_req, 0);
      chk("R12 hs released", hs_oe, 0);
      cs_n = 1'b1; ds_n = 1'b1;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      repeat (2) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      t_reset();
      t_halfword();
      t_bytes();
      t_ro_write();
      t_void();
      t_busy();
      t_ack_hold();
      t_mode1();
      t_early_cs();
      t_async_reset();
      done = 1;
   end

   initial begin
      for (int c = 0; c < 200000; c++) begin
         @(posedge clk);
         if (done) break;
      end
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
      end
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end
endmodule